// File: doc/BRIEF.md
# IMA Transmit Link Membership Controller

This block keeps the transmit-side control word for each of four physical links and moves every link between plain single-link (UNI) operation and membership of an inverse-multiplexing (IMA) group. Software writes a control word per link that names the group, asks for IMA or UNI operation, and allows or stops user cells. The controller does not act on a mode request at once. It applies the request on the next end-of-frame pulse of the link's own group, and it reports the mode actually in effect on a separate status output that software polls.

Two protections are built in. First, a link's group number can only change while its status shows UNI mode. A write that tries to change it at any other time leaves the old group in place and raises a sticky per-link error flag. Second, the last active member of a group may not leave until the shared transmit queue reports empty. Each link also holds a 5-bit identifier, which the block stores but does not check for duplicates.

Each link runs a four-state machine. The states are LS_UNI (out of group), LS_JOIN (IMA requested, waiting for a frame boundary), LS_IMA (member) and LS_LEAVE (UNI requested, waiting for a frame boundary and, if last, for the queue to drain). The transitions are:
- LS_UNI→LS_JOIN: request without a frame pulse.
- LS_UNI→LS_IMA: request arriving together with a frame pulse.
- LS_JOIN→LS_IMA: frame pulse.
- LS_JOIN→LS_UNI: request withdrawn.
- LS_IMA→LS_LEAVE: UNI requested and the exit is not yet allowed.
- LS_IMA→LS_UNI: direct exit when the gate is already open.
- LS_LEAVE→LS_UNI: frame pulse with the exit gate open.
- LS_LEAVE→LS_IMA: request withdrawn.

Top module: `ima_link_ctrl`

## Requirements
- R1: Control word layout: bits [1:0] are the group number, bit 2 is the mode request (1 = IMA, 0 = UNI), and bit 6 is the user-cell send enable, which also drives `send_en`. Writing 1 to bit 7 clears the link's error flag. On read, bits 3, 4, 5 and 7 return 0.
- R2: After reset, every control word, every identifier, `ima_status` and `grp_err` read as zero.
- R3: An IMA request is applied only on an end-of-frame pulse of the link's own group. The link's `ima_status` bit is 1 in the cycle after the pulse is sampled. Pulses of other groups have no effect.
- R4: While a link's status bit is 0 (UNI), a control write that changes the group number is accepted and raises no error.
- R5: While a link's status bit is 1, a control write with a different group number keeps the old group but writes the other fields. It sets that link's `grp_err` bit, which stays set until a write with bit 7 = 1 and an unchanged group clears it.
- R6: A UNI request on a link that is not the last active member of its group takes effect on the next own-group frame pulse, whatever the level of `queue_empty`.
- R7: A UNI request on the last active member of a group stays pending, with the status bit held at 1, until a frame pulse arrives while `queue_empty` is 1.
- R8: Each link has a 5-bit identifier, written and read with select = 1. Equal identifiers on several links are stored without complaint.
- R9: An IMA request withdrawn before any own-group frame pulse is cancelled, and a later pulse leaves the status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = link identifier |
| wr_link | input | 2 | Link addressed by the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | 0 = control word, 1 = link identifier |
| rd_link | input | 2 | Link addressed by the read |
| rd_data | output | 8 | Read data (combinational) |
| frame_end | input | 4 | One end-of-frame pulse per group |
| queue_empty | input | 1 | Shared transmit queue is empty |
| ima_status | output | 4 | Per link: 1 = IMA mode in effect |
| send_en | output | 4 | Per link user-cell send enable |
| grp_err | output | 4 | Per link sticky rejected-group-write flag |

## Verification
A link machine stuck in a wrong state shows up on `ima_status` on the first own-group frame pulse after the request, because status is a direct decode of the registered state. A wrong last-member decision shows up as a status bit that clears while `queue_empty` is low, or that never clears after the queue drains. A lock fault shows up in the next read of the control word or in `grp_err` one cycle after the offending write. The bench therefore checks status right after each pulse, and also in the idle cycles before it, to catch early transitions.

// File: rtl/ima_lc_pkg.sv
package ima_lc_pkg;
    typedef enum logic [1:0] {
        LS_UNI   = 2'd0,
        LS_JOIN  = 2'd1,
        LS_IMA   = 2'd2,
        LS_LEAVE = 2'd3
    } link_state_e;

    localparam int CW_W        = 8;
    localparam int BIT_MODE    = 2;
    localparam int BIT_SEND    = 6;
    localparam int BIT_ERR_CLR = 7;
endpackage

// File: rtl/ima_lc_regs.sv
module ima_lc_regs
    import ima_lc_pkg::*;
#(
    parameter int N_LINK = 4,
    parameter int GRP_W  = 2,
    parameter int LID_W  = 5,
    parameter int AW     = $clog2(N_LINK)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_sel,
    input  logic [AW-1:0]                wr_link,
    input  logic [CW_W-1:0]              wr_data,
    input  logic                         rd_sel,
    input  logic [AW-1:0]                rd_link,
    output logic [CW_W-1:0]              rd_data,
    input  logic [N_LINK-1:0]            stat_ima,
    output logic [N_LINK-1:0][GRP_W-1:0] grp_o,
    output logic [N_LINK-1:0]            req_o,
    output logic [N_LINK-1:0]            send_o,
    output logic [N_LINK-1:0]            err_o
);
    logic [N_LINK-1:0][GRP_W-1:0] grp_q;
    logic [N_LINK-1:0][LID_W-1:0] lid_q;
    logic [N_LINK-1:0]            req_q;
    logic [N_LINK-1:0]            send_q;
    logic [N_LINK-1:0]            err_q;

    for (genvar i = 0; i < N_LINK; i++) begin : g_link
        logic hit_ctl;
        logic hit_lid;
        logic grp_diff;
        assign hit_ctl  = wr_en && !wr_sel && (wr_link == AW'(i));
        assign hit_lid  = wr_en &&  wr_sel && (wr_link == AW'(i));
        assign grp_diff = (wr_data[GRP_W-1:0] != grp_q[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_q[i]  <= '0;
                lid_q[i]  <= '0;
                req_q[i]  <= 1'b0;
                send_q[i] <= 1'b0;
                err_q[i]  <= 1'b0;
            end else begin
                if (hit_ctl) begin
                    req_q[i]  <= wr_data[BIT_MODE];
                    send_q[i] <= wr_data[BIT_SEND];
                    if (!stat_ima[i]) grp_q[i] <= wr_data[GRP_W-1:0];
                end
                if (hit_lid) lid_q[i] <= wr_data[LID_W-1:0];
                if (hit_ctl && stat_ima[i] && grp_diff) err_q[i] <= 1'b1;
                else if (hit_ctl && wr_data[BIT_ERR_CLR]) err_q[i] <= 1'b0;
            end
        end

        // R5
        grp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stat_ima[i] |=> $stable(grp_q[i]));

        // R5
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[i] && !(hit_ctl && wr_data[BIT_ERR_CLR])) |=> err_q[i]);
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[LID_W-1:0] = lid_q[rd_link];
        end else begin
            rd_data[GRP_W-1:0] = grp_q[rd_link];
            rd_data[BIT_MODE]  = req_q[rd_link];
            rd_data[BIT_SEND]  = send_q[rd_link];
        end
    end

    assign grp_o  = grp_q;
    assign req_o  = req_q;
    assign send_o = send_q;
    assign err_o  = err_q;
endmodule

// File: rtl/ima_lc_member.sv
module ima_lc_member #(
    parameter int N_LINK = 4,
    parameter int GRP_W  = 2
) (
    input  logic [N_LINK-1:0][GRP_W-1:0] grp,
    input  logic [N_LINK-1:0]            active,
    output logic [N_LINK-1:0]            last
);
    for (genvar i = 0; i < N_LINK; i++) begin : g_last
        always_comb begin
            last[i] = 1'b1;
            for (int j = 0; j < N_LINK; j++) begin
                if ((j != i) && active[j] && (grp[j] == grp[i])) last[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ima_lc_link_fsm.sv
module ima_lc_link_fsm
    import ima_lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_ima,
    input  logic frame_end,
    input  logic last,
    input  logic q_empty,
    output logic ima_o,
    output logic active_o
);
    link_state_e state_q, state_d;
    logic        exit_ok;

    assign exit_ok = frame_end && (!last || q_empty);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_UNI;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_UNI:   if (req_ima) state_d = frame_end ? LS_IMA : LS_JOIN;
            LS_JOIN:  if (!req_ima) state_d = LS_UNI;
                      else if (frame_end) state_d = LS_IMA;
            LS_IMA:   if (!req_ima) state_d = exit_ok ? LS_UNI : LS_LEAVE;
            LS_LEAVE: if (req_ima) state_d = LS_IMA;
                      else if (exit_ok) state_d = LS_UNI;
            default:  state_d = LS_UNI;
        endcase
    end

    always_comb begin
        ima_o    = (state_q == LS_IMA) || (state_q == LS_LEAVE);
        active_o = (state_q == LS_IMA);
    end

    // R3
    join_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ima_o) |-> $past(frame_end));

    // R7
    leave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ima_o) |-> $past(frame_end && (!last || q_empty)));

    // R9
    cancel_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_JOIN && !req_ima) |=> !ima_o);
endmodule

// File: rtl/ima_link_ctrl.sv
module ima_link_ctrl
    import ima_lc_pkg::*;
#(
    parameter int N_LINK = 4,
    parameter int GRP_W  = 2,
    parameter int LID_W  = 5,
    localparam int N_GRP = 1 << GRP_W,
    localparam int AW    = $clog2(N_LINK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [AW-1:0]     wr_link,
    input  logic [CW_W-1:0]   wr_data,
    input  logic              rd_sel,
    input  logic [AW-1:0]     rd_link,
    output logic [CW_W-1:0]   rd_data,
    input  logic [N_GRP-1:0]  frame_end,
    input  logic              queue_empty,
    output logic [N_LINK-1:0] ima_status,
    output logic [N_LINK-1:0] send_en,
    output logic [N_LINK-1:0] grp_err
);
    logic [N_LINK-1:0][GRP_W-1:0] grp;
    logic [N_LINK-1:0]            req;
    logic [N_LINK-1:0]            active;
    logic [N_LINK-1:0]            last;

    ima_lc_regs #(.N_LINK(N_LINK), .GRP_W(GRP_W), .LID_W(LID_W), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_link  (wr_link),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_link  (rd_link),
        .rd_data  (rd_data),
        .stat_ima (ima_status),
        .grp_o    (grp),
        .req_o    (req),
        .send_o   (send_en),
        .err_o    (grp_err)
    );

    ima_lc_member #(.N_LINK(N_LINK), .GRP_W(GRP_W)) u_member (
        .grp    (grp),
        .active (active),
        .last   (last)
    );

    for (genvar i = 0; i < N_LINK; i++) begin : g_fsm
        ima_lc_link_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_ima   (req[i]),
            .frame_end (frame_end[grp[i]]),
            .last      (last[i]),
            .q_empty   (queue_empty),
            .ima_o     (ima_status[i]),
            .active_o  (active[i])
        );
    end
endmodule

// File: tb/tb_ima_link_ctrl.sv
module tb_ima_link_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [1:0] wr_link = '0, rd_link = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] frame_end = '0;
    logic       queue_empty = 1'b0;
    logic [3:0] ima_status, send_en, grp_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         kind;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    ima_link_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_link(wr_link), .wr_data(wr_data), .rd_sel(rd_sel), .rd_link(rd_link),
        .rd_data(rd_data), .frame_end(frame_end), .queue_empty(queue_empty),
        .ima_status(ima_status), .send_en(send_en), .grp_err(grp_err)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin : mon
        exp_t       e;
        logic [7:0] obs;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            case (e.kind)
                0:       obs = rd_data;
                1:       obs = {4'b0, ima_status};
                2:       obs = {4'b0, grp_err};
                default: obs = {4'b0, send_en};
            endcase
            checks++;
            if (obs !== e.val) begin
                errors++;
                $display("FAIL %s kind=%0d got %h exp %h", e.tag, e.kind, obs, e.val);
            end
        end
    end

    task automatic expect_v(input int kind, input logic [7:0] val, input string tag);
        exp_t e;
        e.kind = kind; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [1:0] link, input logic sel, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_link = link; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] link, input logic sel, input logic [7:0] v, input string tag);
        rd_link = link; rd_sel = sel;
        expect_v(0, v, tag);
    endtask

    task automatic pulse(input int g);
        @(posedge clk); #1;
        frame_end = 4'(1 << g);
        @(posedge clk); #1;
        frame_end = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state
        expect_v(1, 8'h00, "R2 status");
        expect_v(2, 8'h00, "R2 err");
        rd(0, 0, 8'h00, "R2 ctrl");
        idle(1);
        rd(0, 1, 8'h00, "R2 lid");
        idle(1);

        // R1/R3 link0 joins group 1
        wr(0, 0, 8'h45);
        rd(0, 0, 8'h45, "R1 readback");
        expect_v(3, 8'h01, "R1 send_en");
        idle(3);
        expect_v(1, 8'h00, "R3 no frame yet");
        pulse(2);
        expect_v(1, 8'h00, "R3 other group pulse");
        pulse(1);
        expect_v(1, 8'h01, "R3 join applied");
        idle(1);

        // link1 joins group 1
        wr(1, 0, 8'h45);
        pulse(1);
        expect_v(1, 8'h03, "R3 second join");
        idle(1);

        // R5 group lock while in IMA
        wr(0, 0, 8'h46);
        rd(0, 0, 8'h45, "R5 group kept");
        expect_v(2, 8'h01, "R5 err set");
        idle(3);
        expect_v(2, 8'h01, "R5 err sticky");
        wr(0, 0, 8'hC5);
        expect_v(2, 8'h00, "R5 err cleared");
        rd(0, 0, 8'h45, "R1 bit7 reads zero");
        idle(1);

        // R6 non-last leave, queue not empty
        wr(0, 0, 8'h41);
        idle(2);
        expect_v(1, 8'h03, "R6 pending before frame");
        pulse(1);
        expect_v(1, 8'h02, "R6 leave applied");
        idle(1);

        // R4 group change accepted in UNI
        wr(0, 0, 8'h42);
        rd(0, 0, 8'h42, "R4 group changed");
        expect_v(2, 8'h00, "R4 no error");
        idle(1);

        // R7 last member leave waits for queue
        wr(1, 0, 8'h41);
        pulse(1);
        expect_v(1, 8'h02, "R7 held, queue busy");
        idle(1);
        queue_empty = 1'b1;
        idle(2);
        expect_v(1, 8'h02, "R7 held, no frame");
        pulse(1);
        expect_v(1, 8'h00, "R7 leave after drain");
        idle(1);

        // R8 duplicate identifiers
        wr(2, 1, 8'h1F);
        wr(3, 1, 8'h1F);
        rd(2, 1, 8'h1F, "R8 lid link2");
        idle(1);
        rd(3, 1, 8'h1F, "R8 lid link3");
        idle(1);

        // R9 cancelled join
        wr(2, 0, 8'h04);
        wr(2, 0, 8'h00);
        pulse(0);
        expect_v(1, 8'h00, "R9 cancelled");
        idle(1);

        // R1 reserved bits read zero, send_en vector
        wr(3, 0, 8'hFF);
        rd(3, 0, 8'h47, "R1 reserved zero");
        expect_v(3, 8'h0B, "R1 send_en vector");
        idle(1);
        pulse(3);
        expect_v(1, 8'h08, "R3 link3 join");
        idle(1);
        wr(3, 0, 8'h44);
        expect_v(2, 8'h08, "R5 link3 err");
        rd(3, 0, 8'h47, "R5 link3 group kept");
        idle(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule